// File: doc/BRIEF.md
# Pixel Clock Synthesizer Parameter Search

This block turns a requested pixel period, given in picoseconds, into three integer settings for a clock synthesizer. The settings are a multiplier `k`, a divider `n` and a post-divider shift `p2`. The synthesizer then produces a period of `256016 * k / n`, shifted right by `p2`.

A host presents the period and pulses `start`. The block first clamps very short requests and rejects very long ones. It then picks the post-divider shift. After that it tries every multiplier from 1 to 31 in turn. For each multiplier it runs one restoring division, one quotient bit per clock. It keeps the candidate with the smallest remainder whose quotient is a legal divider.

When the search ends, `done` pulses for one cycle. At that moment the results and an error flag appear on the outputs, and they stay there until the next completion. With the default 24-bit datapath, a full search keeps `busy` high for 31 x 24 = 744 cycles.

Top module: `pixclk_search`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `err` are low and `k_out`, `n_out` and `p2_out` are zero.
- R2: A `start` seen while `busy` is low and the request is accepted raises `busy` on the next cycle. `busy` then stays high for exactly 744 cycles. In the cycle where `busy` falls, `done` is high for that single cycle.
- R3: A request below 5000 ps is treated exactly as a request of 5000 ps.
- R4: A request above 2048128 ps (the base 256016 times 8) is rejected. `done` and `err` are high in the cycle after `start`, `busy` never rises, and all three parameters read zero.
- R5: `p2_out` is 3 when the clamped request times 16 is less than 256016, and 2 otherwise. For example, 16000 gives 3 and 16001 gives 2.
- R6: With l equal to the clamped request shifted left by `p2`, the result is the k in 1..31 that gives the smallest value of (256016·k) mod l among those whose quotient (256016·k)/l lies in 1..127. On a tie in the remainder, the smaller k wins. `n_out` is that quotient.
- R7: When no k yields a legal quotient (for example a request of 2048128), `err` is high at `done` and all three parameters read zero.
- R8: A `start` that arrives while `busy` is high is ignored. The search in progress completes with the result for its own request.
- R9: `k_out`, `n_out`, `p2_out` and `err` change only in a cycle where `done` is high. They hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse; sampled only while idle |
| period | input | 32 | Requested pixel period in picoseconds |
| busy | output | 1 | High while the multiplier search runs |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No legal parameter set for the last request |
| k_out | output | 5 | Selected multiplier |
| n_out | output | 7 | Selected divider |
| p2_out | output | 2 | Selected post-divider shift |

## Verification
A corrupted partial remainder or quotient during a division does not show until `done`, 744 cycles later. It then appears as a wrong `n_out`, or as a different `k_out` winning the remainder race. A miscount in the step or multiplier counter shows sooner, as `busy` falling early or late, and a cycle-accurate model catches that on the exact cycle. Faults in clamping, rejection or shift selection reveal themselves in the first result for requests placed at 5000, 16000/16001 and 2048128/2048129.

// File: rtl/pixclk_search.sv
module pixclk_search #(
  parameter int BASE       = 256016,
  parameter int MIN_PERIOD = 5000,
  parameter int K_LAST     = 31,
  parameter int N_LIMIT    = 128,
  parameter int PW         = 32,
  parameter int DW         = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [PW-1:0]                 period,
  output logic                          busy,
  output logic                          done,
  output logic                          err,
  output logic [$clog2(K_LAST+1)-1:0]   k_out,
  output logic [$clog2(N_LIMIT)-1:0]    n_out,
  output logic [1:0]                    p2_out
);
  localparam int KW = $clog2(K_LAST+1);
  localparam int NW = $clog2(N_LIMIT);
  localparam int CW = $clog2(DW);
  localparam logic [DW-1:0] BASE_V = DW'(BASE);

  logic [CW-1:0] cnt;
  logic [KW-1:0] k_q, best_k;
  logic [NW-1:0] best_n;
  logic [DW-1:0] l_q, acc, quo, best_r;
  logic [1:0]    p2_q;

  logic [PW+3:0] per_w;
  logic [PW-1:0] per_c;
  logic          reject, sel3;
  logic [DW-1:0] l_new;

  assign per_w  = {4'b0, period};
  assign reject = per_w > ((PW+4)'(BASE) << 3);
  assign per_c  = (period < PW'(MIN_PERIOD)) ? PW'(MIN_PERIOD) : period;
  assign sel3   = {per_c, 4'b0} < (PW+4)'(BASE);
  assign l_new  = sel3 ? DW'({per_c, 3'b0}) : DW'({per_c, 2'b0});

  logic [DW:0]   sh, diff;
  logic          ge;
  logic [DW-1:0] nacc, nquo;
  logic          last_step, take;

  assign sh        = {acc, quo[DW-1]};
  assign diff      = sh - {1'b0, l_q};
  assign ge        = ~diff[DW];
  assign nacc      = ge ? diff[DW-1:0] : sh[DW-1:0];
  assign nquo      = {quo[DW-2:0], ge};
  assign last_step = (cnt == CW'(DW-1));
  assign take      = last_step && (nquo != '0) && (nquo < DW'(N_LIMIT)) && (nacc < best_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      k_out <= '0; n_out <= '0; p2_out <= '0;
      cnt <= '0; k_q <= '0; best_k <= '0; best_n <= '0;
      l_q <= '0; acc <= '0; quo <= '0; best_r <= '0; p2_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (reject) begin
            done <= 1'b1; err <= 1'b1;
            k_out <= '0; n_out <= '0; p2_out <= '0;
          end else begin
            busy   <= 1'b1;
            p2_q   <= sel3 ? 2'd3 : 2'd2;
            l_q    <= l_new;
            best_r <= l_new;
            best_k <= '0;
            best_n <= '0;
            k_q    <= KW'(1);
            cnt    <= '0;
            acc    <= '0;
            quo    <= BASE_V;
          end
        end
      end else begin
        acc <= nacc;
        quo <= nquo;
        cnt <= cnt + CW'(1);
        if (last_step) begin
          if (take) begin
            best_k <= k_q;
            best_n <= nquo[NW-1:0];
            best_r <= nacc;
          end
          cnt <= '0;
          acc <= '0;
          quo <= BASE_V * DW'(k_q + KW'(1));
          k_q <= k_q + KW'(1);
          if (k_q == KW'(K_LAST)) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (take) begin
              err <= 1'b0; k_out <= k_q; n_out <= nquo[NW-1:0]; p2_out <= p2_q;
            end else if (best_k != '0) begin
              err <= 1'b0; k_out <= best_k; n_out <= best_n; p2_out <= p2_q;
            end else begin
              err <= 1'b1; k_out <= '0; n_out <= '0; p2_out <= '0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/pixclk_search_chk.sv
module pixclk_search_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [4:0] k_out,
  input logic [6:0] n_out,
  input logic [1:0] p2_out
);
  // R2
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R2
  start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (busy || done));
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && busy) |=> (busy || done));
  // R6
  legal_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (k_out != 5'd0 && n_out != 7'd0 && p2_out >= 2'd2));
  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (k_out == 5'd0 && n_out == 7'd0 && p2_out == 2'd0));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(k_out) && $stable(n_out) && $stable(p2_out) && $stable(err)));
endmodule

bind pixclk_search pixclk_search_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .k_out(k_out), .n_out(n_out), .p2_out(p2_out)
);

// File: tb/pixclk_search_tb_top.sv
module pixclk_search_tb_top;
  localparam longint BASE = 256016;
  localparam int RUN_CYC = 744;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0;
  logic [31:0] period = '0;
  logic        busy, done, err;
  logic [4:0]  k_out;
  logic [6:0]  n_out;
  logic [1:0]  p2_out;

  pixclk_search dut_i (.clk(clk), .rst_n(rst_n), .start(start), .period(period),
    .busy(busy), .done(done), .err(err), .k_out(k_out), .n_out(n_out), .p2_out(p2_out));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void find(input longint per, output int k, output int n,
                               output int p2, output bit e);
    longint c, l, best, m;
    k = 0; n = 0; p2 = 0; e = 1;
    if (per > BASE * 8) return;
    c = (per < 5000) ? 5000 : per;
    p2 = (c * 16 < BASE) ? 3 : 2;
    l = c << p2;
    best = l;
    for (int kk = 1; kk <= 31; kk++) begin
      m = BASE * kk;
      if ((m / l) != 0 && (m / l) < 128 && (m % l) < best) begin
        best = m % l; k = kk; n = int'(m / l);
      end
    end
    if (k == 0) begin p2 = 0; return; end
    e = 0;
  endfunction

  int mcnt = 0;
  logic m_done = 1'b0, m_err = 1'b0;
  int m_k = 0, m_n = 0, m_p2 = 0;
  int pk, pn, pp; bit pe;

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= 0; m_done <= 1'b0; m_err <= 1'b0; m_k <= 0; m_n <= 0; m_p2 <= 0;
    end else if (mcnt == 0 && start) begin
      int a, b, c2; bit d;
      find(longint'(period), a, b, c2, d);
      if (longint'(period) > BASE * 8) begin
        m_done <= 1'b1; m_err <= 1'b1; m_k <= 0; m_n <= 0; m_p2 <= 0;
      end else begin
        pk = a; pn = b; pp = c2; pe = d;
        mcnt <= RUN_CYC; m_done <= 1'b0;
      end
    end else if (mcnt > 0) begin
      if (mcnt == 1) begin
        m_done <= 1'b1; m_err <= pe; m_k <= pk; m_n <= pn; m_p2 <= pp;
      end else m_done <= 1'b0;
      mcnt <= mcnt - 1;
    end else m_done <= 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (mcnt != 0), "R2", "busy", busy, mcnt != 0);
      chk(done == m_done, "R2", "done", done, m_done);
      chk(err == m_err, "R6", "err", err, m_err);
      chk(k_out == m_k, "R6", "k", k_out, m_k);
      chk(n_out == m_n, "R6", "n", n_out, m_n);
      chk(p2_out == m_p2, "R5", "p2", p2_out, m_p2);
    end
  end

  task automatic run(input longint per, input string req);
    int k, n, p2; bit e;
    @(negedge clk); period = 32'(per); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    find(per, k, n, p2, e);
    chk(err == e, req, "err", err, e);
    chk(k_out == k, req, "k", k_out, k);
    chk(n_out == n, req, "n", n_out, n);
    chk(p2_out == p2, req, "p2", p2_out, p2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k0, n0, p0;
    logic e0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && err == 0, "R1", "flags", {busy, done, err}, 0);
    chk(k_out == 0 && n_out == 0 && p2_out == 0, "R1", "params", {k_out, n_out, p2_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "after release", {busy, done}, 0);

    run(39722, "R6");
    run(100000, "R6");
    run(16000, "R5");
    run(16001, "R5");
    run(0, "R3");
    k0 = k_out; n0 = n_out; p0 = p2_out; e0 = err;
    run(5000, "R3");
    chk(k_out == k0 && n_out == n0 && p2_out == p0 && err == e0, "R3", "clamp k",
        k_out, k0);
    run(2048128, "R7");
    chk(err == 1, "R7", "no candidate err", err, 1);
    run(2048129, "R4");
    chk(err == 1 && busy == 0, "R4", "reject", {err, busy}, 2);

    // R8 start during busy is ignored
    @(negedge clk); period = 20000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    period = 30000; start = 1'b1;
    @(negedge clk); start = 1'b0; period = 0;
    while (!done) @(negedge clk);
    begin
      int k, n, p2; bit e;
      find(20000, k, n, p2, e);
      chk(k_out == k, "R8", "k", k_out, k);
      chk(n_out == n, "R8", "n", n_out, n);
    end

    // R9 hold after completion
    k0 = k_out; n0 = n_out; p0 = p2_out;
    period = 7000;
    repeat (20) @(negedge clk);
    chk(k_out == k0 && n_out == n0 && p2_out == p0, "R9", "hold k", k_out, k0);
    chk(busy == 0, "R9", "idle busy", busy, 0);

    run(250000, "R6");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule